// File: doc/BRIEF.md
# Deep-Sleep Tick Timer

This block is a free-running counter meant to keep time while the rest of a chip sleeps. It counts ticks from one of two slow sources: an external crystal-derived tick or an internal RC tick. Both sources reach the block as single-cycle enable pulses in the system clock domain. A power-of-two prescaler sits between the selected source and the counter, so a 32.768 kHz source can be brought down to 1024 counts per second. At that rate the 32-bit counter rolls over after about 48.5 days.

Three events can raise the interrupt line. Two are compare channels, each with its own compare value, and the third is the counter rolling over. Each event sets a sticky status bit, and software clears a status bit by writing a one to it. A mask register selects which status bits drive the single interrupt output. A debug-pause control lets the counter freeze while a debug-halt input is high. A plain single-cycle register port gives access to all registers. Reads return data on the cycle after the request.

Top module: `sleep_tick_timer`

## Requirements
- R1: The counter is CNT_W bits wide (32 by default). It changes only by exactly +1 per prescaler step and goes from all-ones to zero. It is read at offset 5, and writes to offset 5 are ignored.
- R2: The counter advances only while the enable bit (control bit 1) is 1.
- R3: Control bit 0 picks the source. 1 counts `tick_ext` pulses and 0 counts `tick_rc` pulses. Pulses on the source that is not selected have no effect.
- R4: Control bits [6:4] hold an exponent N, and the counter advances once per 2^N qualifying source ticks. N = 0 is undivided. Values above 5 act as 5.
- R5: Any write to the control register (offset 0) restarts the prescaler from zero, and the counter does not advance in that cycle. The counter value itself is kept.
- R6: When control bit 10 is 1 and `dbg_halt` is high, source ticks are ignored. When bit 10 is 0, counting continues during a halt.
- R7: Status bit 1 (channel A, compare at offset 3) and status bit 2 (channel B, compare at offset 4) set when the counter steps to a value equal to that channel's compare value. Writing a compare value equal to the present count sets nothing.
- R8: Status bit 0 sets on the step that takes the counter from all-ones to zero.
- R9: Status is at offset 2. Writing 1 to a bit clears it, and writing 0 leaves it. A set and a clear of the same bit in one cycle leave it set.
- R10: The mask register is at offset 1, bits [2:0] line up with the status bits, and it resets to zero. `irq` is a register equal to the OR over the three bits of (status AND mask), and it updates on the same edge as status and mask.
- R11: After reset the control, mask, status, compare and counter registers are all zero and `irq` is low.
- R12: A read request (`bus_sel` high, `bus_wr` low) returns the addressed register on `bus_rdata` one cycle later, zero-extended. The returned count is the value held in the cycle the read was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ext | input | 1 | One-cycle tick from the external slow source |
| tick_rc | input | 1 | One-cycle tick from the internal RC source |
| dbg_halt | input | 1 | Debug-halt indication |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Masked interrupt request |

## Verification
On every cycle the bound checker enforces several rules. The counter only ever moves by one, and it stays frozen while disabled or paused by debug. A roll-over always leaves the wrap flag set, and status bits fall only after a status write. `irq` always matches the masked status. Other behaviour can only be shown by the bench's scenarios, because each needs a known sequence of ticks and register writes. That covers the prescaler division ratios and the saturation of N, and the choice of source. It also covers whether compare flags fire on the exact matching step and not on a compare write, and whether a set beats a clear in the same cycle.

// File: rtl/sltm_pkg.sv
package sltm_pkg;
  localparam int REG_W  = 32;
  localparam int NCMP   = 2;
  localparam int NFLAG  = NCMP + 1;
  localparam int EXP_W  = 3;

  typedef enum logic [2:0] {
    OFS_CTRL   = 3'd0,
    OFS_MASK   = 3'd1,
    OFS_STATUS = 3'd2,
    OFS_CMPA   = 3'd3,
    OFS_CMPB   = 3'd4,
    OFS_COUNT  = 3'd5
  } reg_ofs_e;

  localparam int BIT_SRC   = 0;
  localparam int BIT_EN    = 1;
  localparam int BIT_EXP   = 4;
  localparam int BIT_PAUSE = 10;
endpackage

// File: rtl/sltm_prescale.sv
module sltm_prescale #(
  parameter int PRE_W = 5,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             en,
  input  logic             src_sel,
  input  logic             tick_ext,
  input  logic             tick_rc,
  input  logic             pause,
  input  logic             halt,
  input  logic [EXP_W-1:0] exp_n,
  output logic             step
);
  logic [PRE_W-1:0] pc_q;
  logic [PRE_W-1:0] limit;
  logic             live;
  logic             tick_sel;

  always_comb begin
    tick_sel = src_sel ? tick_ext : tick_rc;
    live     = en && tick_sel && !(pause && halt) && !restart;
    if (int'(exp_n) >= PRE_W) limit = '1;
    else limit = PRE_W'((1 << exp_n) - 1);
    step = live && (pc_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) pc_q <= '0;
    else if (live) pc_q <= (pc_q == limit) ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/sltm_counter.sv
module sltm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);
  always_comb begin
    cnt_nxt = cnt + 1'b1;
    wrap    = step && (&cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (step) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/sltm_events.sv
module sltm_events #(
  parameter int CNT_W = 32,
  parameter int NCMP  = 2,
  localparam int NF   = NCMP + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic                       wrap,
  input  logic [CNT_W-1:0]           cnt_nxt,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp,
  input  logic                       clr_en,
  input  logic [NF-1:0]              clr_bits,
  input  logic [NF-1:0]              mask_nxt,
  output logic [NF-1:0]              flags,
  output logic                       irq
);
  logic [NF-1:0] set_v;
  logic [NF-1:0] flags_d;

  assign set_v[0] = wrap;
  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign set_v[i+1] = step && (cnt_nxt == cmp[i]);
  end

  always_comb begin
    flags_d = flags;
    if (clr_en) flags_d = flags_d & ~clr_bits;
    flags_d = flags_d | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      irq   <= |(flags_d & mask_nxt);
    end
  end
endmodule

// File: rtl/sleep_tick_timer.sv
module sleep_tick_timer
  import sltm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 5,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ext,
  input  logic              tick_rc,
  input  logic              dbg_halt,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  logic             ctrl_src, ctrl_en, ctrl_pause;
  logic [EXP_W-1:0] ctrl_exp;
  logic [NFLAG-1:0] mask_q, mask_d, flags_q;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             step, wrap;
  logic             wr_ctrl, wr_mask, wr_stat, rd_req;

  always_comb begin
    wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    wr_mask = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
    wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
    rd_req  = bus_sel && !bus_wr;
    mask_d  = wr_mask ? bus_wdata[NFLAG-1:0] : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_src   <= 1'b0;
      ctrl_en    <= 1'b0;
      ctrl_pause <= 1'b0;
      ctrl_exp   <= '0;
      mask_q     <= '0;
    end else begin
      mask_q <= mask_d;
      if (wr_ctrl) begin
        ctrl_src   <= bus_wdata[BIT_SRC];
        ctrl_en    <= bus_wdata[BIT_EN];
        ctrl_pause <= bus_wdata[BIT_PAUSE];
        ctrl_exp   <= bus_wdata[BIT_EXP +: EXP_W];
      end
    end
  end

  for (genvar c = 0; c < NCMP; c++) begin : g_cmpreg
    always_ff @(posedge clk) begin
      if (rst) cmp_q[c] <= '0;
      else if (bus_sel && bus_wr && (bus_addr == ADDR_W'(int'(OFS_CMPA) + c)))
        cmp_q[c] <= bus_wdata[CNT_W-1:0];
    end
  end

  sltm_prescale #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst(rst), .restart(wr_ctrl), .en(ctrl_en), .src_sel(ctrl_src),
    .tick_ext(tick_ext), .tick_rc(tick_rc), .pause(ctrl_pause), .halt(dbg_halt),
    .exp_n(ctrl_exp), .step(step)
  );

  sltm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .cnt(cnt_q), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  sltm_events #(.CNT_W(CNT_W), .NCMP(NCMP)) u_evt (
    .clk(clk), .rst(rst), .step(step), .wrap(wrap), .cnt_nxt(cnt_nxt), .cmp(cmp_q),
    .clr_en(wr_stat), .clr_bits(bus_wdata[NFLAG-1:0]), .mask_nxt(mask_d),
    .flags(flags_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_req) begin
      bus_rdata <= '0;
      case (bus_addr)
        ADDR_W'(OFS_CTRL): begin
          bus_rdata[BIT_SRC]             <= ctrl_src;
          bus_rdata[BIT_EN]              <= ctrl_en;
          bus_rdata[BIT_PAUSE]           <= ctrl_pause;
          bus_rdata[BIT_EXP +: EXP_W]    <= ctrl_exp;
        end
        ADDR_W'(OFS_MASK):   bus_rdata[NFLAG-1:0] <= mask_q;
        ADDR_W'(OFS_STATUS): bus_rdata[NFLAG-1:0] <= flags_q;
        ADDR_W'(OFS_CMPA):   bus_rdata[CNT_W-1:0] <= cmp_q[0];
        ADDR_W'(OFS_CMPB):   bus_rdata[CNT_W-1:0] <= cmp_q[1];
        ADDR_W'(OFS_COUNT):  bus_rdata[CNT_W-1:0] <= cnt_q;
        default:             bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sltm_chk.sv
module sltm_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cnt,
  input logic              en,
  input logic              pause,
  input logic              halt,
  input logic [2:0]        flags,
  input logic [2:0]        mask,
  input logic              irq,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr
);
  logic started;
  always_ff @(posedge clk) started <= !rst;

  // R1
  cnt_step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (started && cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));

  // R2
  cnt_hold_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(en)) |-> $stable(cnt));

  // R6
  cnt_hold_paused_chk: assert property (@(posedge clk) disable iff (rst)
    (started && $past(pause && halt)) |-> $stable(cnt));

  // R8
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (started && (&$past(cnt)) && cnt == '0) |-> flags[0]);

  // R9
  flag_fall_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    (started && $past(flags) != '0 && (($past(flags) & ~flags) != '0))
      |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(2)));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    started |-> (irq == |(flags & mask)));
endmodule

bind sleep_tick_timer sltm_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_sltm_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .en(ctrl_en), .pause(ctrl_pause),
  .halt(dbg_halt), .flags(flags_q), .mask(mask_q), .irq(irq),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/sleep_tick_timer_bench.sv
module sleep_tick_timer_bench;
  localparam int CW = 8;
  logic clk = 0, rst = 1;
  logic tick_ext = 0, tick_rc = 0, dbg_halt = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic rd_pend = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  sleep_tick_timer #(.CNT_W(CW)) u_sleep_tick_timer (
    .clk(clk), .rst(rst), .tick_ext(tick_ext), .tick_rc(tick_rc), .dbg_halt(dbg_halt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always @(posedge clk) rd_pend <= bus_sel && !bus_wr;

  // monitor: pops expected read data one cycle after each read request
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read got %0h expected %0h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    @(negedge clk);
  endtask

  task automatic ticks(input bit ext, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (ext) tick_ext = 1; else tick_rc = 1;
      @(negedge clk); tick_ext = 0; tick_rc = 0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst = 0;
    // R11 reset state
    chk_irq(0, "R11 irq");
    rd(0, 0, "R11 ctrl"); rd(1, 0, "R11 mask"); rd(2, 0, "R11 status");
    rd(3, 0, "R11 cmpa"); rd(5, 0, "R11 count");
    // R2 disabled
    ticks(0, 3); rd(5, 0, "R2 disabled hold");
    // R3 rc source, undivided
    wr(0, 32'h2); rd(0, 32'h2, "R12 ctrl readback");
    ticks(0, 5); rd(5, 5, "R3 rc counts");
    ticks(1, 3); rd(5, 5, "R3 ext ignored");
    // R4/R5 ext, N=2
    wr(0, 32'h23); ticks(1, 4); rd(5, 6, "R4 div4 first");
    ticks(1, 3); rd(5, 6, "R4 div4 partial");
    ticks(0, 2); ticks(1, 1); rd(5, 7, "R4 div4 second / R3 rc ignored");
    // R4 saturation N=7 acts as 5; R5 restart
    wr(0, 32'h73); ticks(1, 31); rd(5, 7, "R4 sat partial");
    ticks(1, 1); rd(5, 8, "R4 sat step");
    // R5 control write in same cycle as tick: no advance
    wr(0, 32'h2);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h2; tick_rc = 1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; tick_rc = 0;
    rd(5, 8, "R5 ctrl write blocks step");
    // R6 debug pause
    wr(0, 32'h402); dbg_halt = 1; ticks(0, 3); rd(5, 8, "R6 paused");
    wr(0, 32'h2); ticks(0, 2); rd(5, 10, "R6 no pause while halted");
    dbg_halt = 0;
    // R7 compare A
    wr(3, 12); wr(4, 200); ticks(0, 2);
    rd(2, 2, "R7 cmpa flag"); chk_irq(0, "R10 masked");
    wr(1, 2); chk_irq(1, "R10 unmasked");
    wr(2, 0); rd(2, 2, "R9 write zero keeps");
    wr(2, 2); rd(2, 0, "R9 w1c"); chk_irq(0, "R10 cleared");
    // R7 compare B, R8 wrap
    ticks(0, 243); rd(5, 255, "R1 at max"); rd(2, 4, "R7 cmpb flag");
    ticks(0, 1); rd(5, 0, "R1 wraps"); rd(2, 5, "R8 wrap flag");
    wr(1, 1); chk_irq(1, "R10 wrap irq");
    // R9 set wins over clear
    wr(3, 1);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 2; bus_wdata = 7; tick_rc = 1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; tick_rc = 0;
    rd(2, 2, "R9 set beats clear"); chk_irq(0, "R10 after clear");
    // R7 compare write equal to count
    wr(2, 7); wr(3, 1); rd(2, 0, "R7 no flag on compare write");
    // R1 count writes ignored
    wr(5, 32'h55); rd(5, 1, "R1 count write ignored");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule